// File: doc/BRIEF.md
# Flash Status Ready Poller

This block is a small sequencer that answers one question for a serial NOR flash controller: is the memory able to take a new command? It does not shift bits itself. Instead it hands complete command descriptions to a generic SPI command engine: opcode, address byte count, dummy cycle count, data length and a wire-mode flag. It then collects the bytes the engine returns. One poll reads the legacy status register first and the flag status register second. The two readings are then combined into one verdict.

If the flag status byte reports a failed erase or program, the poller recovers by itself. It issues a clear-flags command, then a write-disable command, and finishes with an I/O error together with cause flags. If the engine reports that it cannot perform the flag status read, the verdict rests on the legacy status alone. A cycle budget bounds the whole poll. When the budget runs out, the poll ends with a timeout error.

Each poll starts with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. The verdict outputs are valid from the `done` cycle and stay unchanged until the next accepted `start`.

The sequencer has ten states:
- IDLE: waits for `start`.
- STAT_REQ and STAT_WAIT: issue and complete the legacy status read.
- FLAG_REQ and FLAG_WAIT: issue and complete the flag status read.
- CLR_REQ and CLR_WAIT: issue and complete the clear-flags command.
- WRDI_REQ and WRDI_WAIT: issue and complete the write-disable command.
- FINISH: pulses `done`.

The transitions are:
- IDLE goes to STAT_REQ on `start`.
- Each REQ state goes to its WAIT state when `cmd_accept` is high.
- STAT_WAIT goes to FINISH on an unsupported completion, and to FLAG_REQ otherwise.
- FLAG_WAIT goes to CLR_REQ on a completion with a failure bit set, and to FINISH otherwise.
- CLR_WAIT goes to WRDI_REQ on completion.
- WRDI_WAIT goes to FINISH on completion.
- FINISH always returns to IDLE.
- An expired budget forces any busy state to FINISH.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `cmd_valid`, `ready`, `io_err`, `timeout_err`, `err_erase`, `err_program` and `err_protect` are all 0.
- R2: A poll first issues the legacy status read: opcode 0x05, no address, no dummy, one data byte, single-wire. While `cmd_valid` is high and `cmd_accept` is low, the command fields hold steady.
- R3: After a supported legacy status read, the block issues the flag status read: opcode 0x70, no address, no dummy, one data byte, single-wire.
- R4: When `octal_mode` is 1 at `start`, both register reads use the `oct_addr_bytes` and `oct_dummy` values captured at `start`, a data length of 2 and `cmd_octal`=1. Only the first returned byte is used. The second byte is discarded.
- R5: `ready` is 1 only when legacy status bit 0 (write in progress) is 0 and flag status bit 7 is 1. The other flag status bits besides 5, 4 and 1 have no effect.
- R6: If flag status bit 5 or bit 4 is 1, the block issues 0x50 (no address, no dummy, no data), then 0x04 (no address, no dummy, no data), and finishes with `io_err`=1 and `ready`=0.
- R7: On a failure, `err_erase` equals bit 5 and `err_program` equals bit 4 only when bit 5 is 0. `err_protect` equals bit 1. With no failure, all three cause flags are 0.
- R8: If the engine completes the flag status read as unsupported, `ready` equals "legacy status bit 0 is 0". No error is reported and no recovery is issued.
- R9: If the engine completes the legacy status read as unsupported, the poll ends with `io_err`=1 and all cause flags 0, without a flag status read.
- R10: If a poll has not finished after TIMEOUT_CYCLES busy cycles, `cmd_valid` drops and the poll ends with `timeout_err`=1, `ready`=0 and `io_err`=0. `busy` is high for exactly TIMEOUT_CYCLES cycles.
- R11: `done` is a one-cycle pulse with `busy` low. The verdict outputs hold until the next poll starts. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (taken only when idle) |
| octal_mode | input | 1 | Register reads use the octal double-rate layout |
| oct_addr_bytes | input | AB_W | Address byte count for octal register reads |
| oct_dummy | input | DM_W | Dummy cycle count for octal register reads |
| cmd_valid | output | 1 | Command request to the engine |
| cmd_accept | input | 1 | Engine has taken the command |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr_bytes | output | AB_W | Address bytes in the command |
| cmd_dummy | output | DM_W | Dummy cycles in the command |
| cmd_data_len | output | 2 | Data bytes to read (0 to 2) |
| cmd_octal | output | 1 | Command runs in octal double-rate mode |
| rsp_valid | input | 1 | A returned data byte is present |
| rsp_data | input | 8 | Returned data byte |
| cmd_fin | input | 1 | Engine has completed the command |
| cmd_unsup | input | 1 | With `cmd_fin`: command was not supported |
| done | output | 1 | Poll finished (one cycle) |
| busy | output | 1 | Poll in progress |
| ready | output | 1 | Flash is ready for a new command |
| io_err | output | 1 | Poll ended in an I/O error |
| timeout_err | output | 1 | Poll ran out of cycles |
| err_erase | output | 1 | Cause: erase failure |
| err_program | output | 1 | Cause: program failure (erase not also failed) |
| err_protect | output | 1 | Cause: protected region touched |

## Verification
On every cycle, the assertions check the following:
- the verdict outputs are mutually consistent: `ready` never appears with an error, the erase and program causes never both appear, and a cause always comes with `io_err`;
- a pending command holds its fields;
- `done` is a lone pulse with `busy` low;
- the budget counter never passes its limit, and budget expiry always lands in FINISH.

Only the bench's scenarios can show the rest. That covers the exact command order and field values for each mode, the verdict for every combination of legacy busy bit and flag status bits, the two unsupported-read outcomes, the exact budget length, and that a mid-poll `start` has no effect.

// File: rtl/flash_poll_pkg.sv
`timescale 1ns/1ps
package flash_poll_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAT_REQ,
        ST_STAT_WAIT,
        ST_FLAG_REQ,
        ST_FLAG_WAIT,
        ST_CLR_REQ,
        ST_CLR_WAIT,
        ST_WRDI_REQ,
        ST_WRDI_WAIT,
        ST_FINISH
    } poll_state_t;

    localparam logic [7:0] OP_READ_STATUS = 8'h05;
    localparam logic [7:0] OP_READ_FLAGS  = 8'h70;
    localparam logic [7:0] OP_CLEAR_FLAGS = 8'h50;
    localparam logic [7:0] OP_WRITE_DIS   = 8'h04;

    localparam int STAT_WIP_BIT    = 0;
    localparam int FLAG_READY_BIT  = 7;
    localparam int FLAG_ERASE_BIT  = 5;
    localparam int FLAG_PROG_BIT   = 4;
    localparam int FLAG_PROT_BIT   = 1;

endpackage

// File: rtl/flash_poll_timer.sv
`timescale 1ns/1ps
module flash_poll_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/flash_status_decode.sv
`timescale 1ns/1ps
module flash_status_decode
    import flash_poll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       have_result,
    input  logic       tmo_hit,
    input  logic [7:0] stat_byte,
    input  logic [7:0] flag_byte,
    input  logic       stat_unsup,
    input  logic       flag_unsup,
    output logic       raw_fail,
    output logic       ready,
    output logic       io_err,
    output logic       timeout_err,
    output logic       err_erase,
    output logic       err_program,
    output logic       err_protect
);
    logic stat_ok;
    logic flag_rdy;
    logic flag_used;
    logic fail_seen;
    logic live;

    always_comb begin
        stat_ok     = ~stat_byte[STAT_WIP_BIT];
        flag_rdy    = flag_byte[FLAG_READY_BIT];
        raw_fail    = flag_byte[FLAG_ERASE_BIT] | flag_byte[FLAG_PROG_BIT];
        flag_used   = !stat_unsup && !flag_unsup;
        fail_seen   = flag_used && raw_fail;
        live        = have_result && !tmo_hit;
        timeout_err = have_result && tmo_hit;
        io_err      = live && (stat_unsup || fail_seen);
        ready       = live && !stat_unsup && !fail_seen && stat_ok
                      && (flag_unsup || flag_rdy);
        err_erase   = live && fail_seen && flag_byte[FLAG_ERASE_BIT];
        err_program = live && fail_seen && flag_byte[FLAG_PROG_BIT]
                      && !flag_byte[FLAG_ERASE_BIT];
        err_protect = live && fail_seen && flag_byte[FLAG_PROT_BIT];
    end

    // R5
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!io_err && !timeout_err));
    // R7
    cause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_erase && err_program));
    // R6
    cause_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_erase || err_program || err_protect) |-> io_err);

endmodule

// File: rtl/flash_poll_fsm.sv
`timescale 1ns/1ps
module flash_poll_fsm
    import flash_poll_pkg::*;
#(
    parameter int AB_W = 3,
    parameter int DM_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            octal_mode,
    input  logic [AB_W-1:0] oct_addr_bytes,
    input  logic [DM_W-1:0] oct_dummy,
    input  logic            cmd_accept,
    input  logic            rsp_valid,
    input  logic [7:0]      rsp_data,
    input  logic            cmd_fin,
    input  logic            cmd_unsup,
    input  logic            tmo_expire,
    input  logic            raw_fail,
    output logic            cmd_valid,
    output logic [7:0]      cmd_opcode,
    output logic [AB_W-1:0] cmd_addr_bytes,
    output logic [DM_W-1:0] cmd_dummy,
    output logic [1:0]      cmd_data_len,
    output logic            cmd_octal,
    output logic            busy,
    output logic            done,
    output logic            tmr_clear,
    output logic            have_result,
    output logic            tmo_hit,
    output logic [7:0]      stat_byte,
    output logic [7:0]      flag_byte,
    output logic            stat_unsup,
    output logic            flag_unsup
);
    poll_state_t state_q, state_d;

    logic            mode_q;
    logic [AB_W-1:0] ab_q;
    logic [DM_W-1:0] dm_q;
    logic            got_q;
    logic            take;

    assign take = (state_q == ST_IDLE) && start;
    assign tmr_clear = take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)      state_d = ST_STAT_REQ;
            ST_STAT_REQ:  if (cmd_accept) state_d = ST_STAT_WAIT;
            ST_STAT_WAIT: if (cmd_fin)    state_d = cmd_unsup ? ST_FINISH : ST_FLAG_REQ;
            ST_FLAG_REQ:  if (cmd_accept) state_d = ST_FLAG_WAIT;
            ST_FLAG_WAIT: if (cmd_fin)    state_d = (!cmd_unsup && raw_fail) ? ST_CLR_REQ : ST_FINISH;
            ST_CLR_REQ:   if (cmd_accept) state_d = ST_CLR_WAIT;
            ST_CLR_WAIT:  if (cmd_fin)    state_d = ST_WRDI_REQ;
            ST_WRDI_REQ:  if (cmd_accept) state_d = ST_WRDI_WAIT;
            ST_WRDI_WAIT: if (cmd_fin)    state_d = ST_FINISH;
            ST_FINISH:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
        if (tmo_expire) state_d = ST_FINISH;
    end

    // captured configuration, returned bytes and verdict inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= 1'b0;
            ab_q        <= '0;
            dm_q        <= '0;
            got_q       <= 1'b0;
            have_result <= 1'b0;
            tmo_hit     <= 1'b0;
            stat_byte   <= 8'h00;
            flag_byte   <= 8'h00;
            stat_unsup  <= 1'b0;
            flag_unsup  <= 1'b0;
        end else begin
            if (take) begin
                mode_q      <= octal_mode;
                ab_q        <= oct_addr_bytes;
                dm_q        <= oct_dummy;
                have_result <= 1'b0;
                tmo_hit     <= 1'b0;
                stat_byte   <= 8'h00;
                flag_byte   <= 8'h00;
                stat_unsup  <= 1'b0;
                flag_unsup  <= 1'b0;
            end
            unique case (state_q)
                ST_STAT_REQ, ST_FLAG_REQ: got_q <= 1'b0;
                ST_STAT_WAIT: begin
                    if (rsp_valid && !got_q) begin
                        stat_byte <= rsp_data;
                        got_q     <= 1'b1;
                    end
                    if (cmd_fin) stat_unsup <= cmd_unsup;
                end
                ST_FLAG_WAIT: begin
                    if (rsp_valid && !got_q) begin
                        flag_byte <= rsp_data;
                        got_q     <= 1'b1;
                    end
                    if (cmd_fin) flag_unsup <= cmd_unsup;
                end
                default: ;
            endcase
            if ((state_d == ST_FINISH) && (state_q != ST_FINISH)) begin
                have_result <= 1'b1;
                tmo_hit     <= tmo_expire;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_valid      = 1'b0;
        cmd_opcode     = 8'h00;
        cmd_addr_bytes = '0;
        cmd_dummy      = '0;
        cmd_data_len   = 2'd0;
        cmd_octal      = 1'b0;
        busy           = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done           = (state_q == ST_FINISH);
        unique case (state_q)
            ST_STAT_REQ, ST_FLAG_REQ: begin
                cmd_valid  = 1'b1;
                cmd_opcode = (state_q == ST_STAT_REQ) ? OP_READ_STATUS : OP_READ_FLAGS;
                cmd_octal  = mode_q;
                if (mode_q) begin
                    cmd_addr_bytes = ab_q;
                    cmd_dummy      = dm_q;
                    cmd_data_len   = 2'd2;
                end else begin
                    cmd_data_len   = 2'd1;
                end
            end
            ST_CLR_REQ, ST_WRDI_REQ: begin
                cmd_valid  = 1'b1;
                cmd_opcode = (state_q == ST_CLR_REQ) ? OP_CLEAR_FLAGS : OP_WRITE_DIS;
                cmd_octal  = mode_q;
            end
            default: ;
        endcase
    end

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_accept && !tmo_expire) |=>
            (cmd_valid && $stable(cmd_opcode) && $stable(cmd_data_len)
             && $stable(cmd_addr_bytes) && $stable(cmd_dummy)));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10
    tmo_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> (done && !cmd_valid));

endmodule

// File: rtl/flash_ready_poller.sv
`timescale 1ns/1ps
module flash_ready_poller #(
    parameter int AB_W           = 3,
    parameter int DM_W           = 5,
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            octal_mode,
    input  logic [AB_W-1:0] oct_addr_bytes,
    input  logic [DM_W-1:0] oct_dummy,
    output logic            cmd_valid,
    input  logic            cmd_accept,
    output logic [7:0]      cmd_opcode,
    output logic [AB_W-1:0] cmd_addr_bytes,
    output logic [DM_W-1:0] cmd_dummy,
    output logic [1:0]      cmd_data_len,
    output logic            cmd_octal,
    input  logic            rsp_valid,
    input  logic [7:0]      rsp_data,
    input  logic            cmd_fin,
    input  logic            cmd_unsup,
    output logic            done,
    output logic            busy,
    output logic            ready,
    output logic            io_err,
    output logic            timeout_err,
    output logic            err_erase,
    output logic            err_program,
    output logic            err_protect
);
    logic       tmo_expire;
    logic       tmr_clear;
    logic       raw_fail;
    logic       have_result;
    logic       tmo_hit;
    logic [7:0] stat_byte;
    logic [7:0] flag_byte;
    logic       stat_unsup;
    logic       flag_unsup;

    flash_poll_fsm #(.AB_W(AB_W), .DM_W(DM_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .octal_mode     (octal_mode),
        .oct_addr_bytes (oct_addr_bytes),
        .oct_dummy      (oct_dummy),
        .cmd_accept     (cmd_accept),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .cmd_fin        (cmd_fin),
        .cmd_unsup      (cmd_unsup),
        .tmo_expire     (tmo_expire),
        .raw_fail       (raw_fail),
        .cmd_valid      (cmd_valid),
        .cmd_opcode     (cmd_opcode),
        .cmd_addr_bytes (cmd_addr_bytes),
        .cmd_dummy      (cmd_dummy),
        .cmd_data_len   (cmd_data_len),
        .cmd_octal      (cmd_octal),
        .busy           (busy),
        .done           (done),
        .tmr_clear      (tmr_clear),
        .have_result    (have_result),
        .tmo_hit        (tmo_hit),
        .stat_byte      (stat_byte),
        .flag_byte      (flag_byte),
        .stat_unsup     (stat_unsup),
        .flag_unsup     (flag_unsup)
    );

    flash_poll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (busy),
        .expired (tmo_expire)
    );

    flash_status_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .have_result (have_result),
        .tmo_hit     (tmo_hit),
        .stat_byte   (stat_byte),
        .flag_byte   (flag_byte),
        .stat_unsup  (stat_unsup),
        .flag_unsup  (flag_unsup),
        .raw_fail    (raw_fail),
        .ready       (ready),
        .io_err      (io_err),
        .timeout_err (timeout_err),
        .err_erase   (err_erase),
        .err_program (err_program),
        .err_protect (err_protect)
    );

endmodule

// File: tb/flash_ready_poller_bench.sv
`timescale 1ns/1ps
module flash_ready_poller_bench;
    localparam int AB_W = 3;
    localparam int DM_W = 5;
    localparam int TMO  = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            octal_mode = 1'b0;
    logic [AB_W-1:0] oct_addr_bytes = '0;
    logic [DM_W-1:0] oct_dummy = 5'd8;
    logic            cmd_valid;
    logic            cmd_accept = 1'b0;
    logic [7:0]      cmd_opcode;
    logic [AB_W-1:0] cmd_addr_bytes;
    logic [DM_W-1:0] cmd_dummy;
    logic [1:0]      cmd_data_len;
    logic            cmd_octal;
    logic            rsp_valid = 1'b0;
    logic [7:0]      rsp_data = 8'h00;
    logic            cmd_fin = 1'b0;
    logic            cmd_unsup = 1'b0;
    logic            done, busy, ready, io_err, timeout_err;
    logic            err_erase, err_program, err_protect;

    always #2 clk = ~clk;

    flash_ready_poller #(.AB_W(AB_W), .DM_W(DM_W), .TIMEOUT_CYCLES(TMO)) u_flash_ready_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .octal_mode(octal_mode),
        .oct_addr_bytes(oct_addr_bytes), .oct_dummy(oct_dummy),
        .cmd_valid(cmd_valid), .cmd_accept(cmd_accept), .cmd_opcode(cmd_opcode),
        .cmd_addr_bytes(cmd_addr_bytes), .cmd_dummy(cmd_dummy),
        .cmd_data_len(cmd_data_len), .cmd_octal(cmd_octal),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_fin(cmd_fin),
        .cmd_unsup(cmd_unsup), .done(done), .busy(busy), .ready(ready),
        .io_err(io_err), .timeout_err(timeout_err), .err_erase(err_erase),
        .err_program(err_program), .err_protect(err_protect)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // responder configuration
    logic [7:0] resp_stat = 8'h00;
    logic [7:0] resp_flag = 8'h80;
    bit resp_stat_unsup = 1'b0;
    bit resp_flag_unsup = 1'b0;
    bit stall_accept = 1'b0;
    bit stall_fin = 1'b0;

    // command log
    logic [7:0]      lg_op  [0:7];
    logic [AB_W-1:0] lg_ab  [0:7];
    logic [DM_W-1:0] lg_dm  [0:7];
    logic [1:0]      lg_len [0:7];
    logic            lg_oct [0:7];
    int lg_n = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural command engine
    initial begin
        logic [7:0] op;
        logic [1:0] len;
        bit un;
        forever begin
            @(negedge clk);
            if (cmd_valid && !stall_accept) begin
                if (lg_n < 8) begin
                    lg_op[lg_n]  = cmd_opcode;
                    lg_ab[lg_n]  = cmd_addr_bytes;
                    lg_dm[lg_n]  = cmd_dummy;
                    lg_len[lg_n] = cmd_data_len;
                    lg_oct[lg_n] = cmd_octal;
                end
                lg_n++;
                op  = cmd_opcode;
                len = cmd_data_len;
                cmd_accept = 1'b1;
                @(negedge clk);
                cmd_accept = 1'b0;
                if (!stall_fin) begin
                    un = (op == 8'h05 && resp_stat_unsup) || (op == 8'h70 && resp_flag_unsup);
                    if (!un) begin
                        for (int i = 0; i < int'(len); i++) begin
                            rsp_valid = 1'b1;
                            rsp_data  = (i == 0) ? ((op == 8'h05) ? resp_stat : resp_flag) : 8'h5A;
                            @(negedge clk);
                        end
                    end
                    rsp_valid = 1'b0;
                    cmd_fin   = 1'b1;
                    cmd_unsup = un;
                    @(negedge clk);
                    cmd_fin   = 1'b0;
                    cmd_unsup = 1'b0;
                end
            end
        end
    end

    function automatic logic [5:0] verdict_vec;
        verdict_vec = {ready, io_err, timeout_err, err_erase, err_program, err_protect};
    endfunction

    // one poll; returns busy cycle count
    task automatic run_poll(input bit extra_start, output int busy_cnt);
        int cyc;
        lg_n = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        busy_cnt = 0;
        while (!done && cyc < 400) begin
            start = extra_start && (cyc == 2);
            if (busy) busy_cnt++;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R11 done reached", {31'd0, done}, 32'd1);
    endtask

    task automatic chk_cmd(input int idx, input string tag, input logic [7:0] op,
                           input logic [AB_W-1:0] ab, input logic [DM_W-1:0] dm,
                           input logic [1:0] len, input logic oct);
        chk({tag, " opcode"}, {24'd0, lg_op[idx]}, {24'd0, op});
        chk({tag, " fields"}, {19'd0, lg_ab[idx], lg_dm[idx], lg_len[idx], lg_oct[idx]},
                              {19'd0, ab, dm, len, oct});
    endtask

    task automatic sweep_case(input bit mode, input int unmode, input bit wip, input int fidx, input bit extra);
        logic [7:0] fl;
        logic [AB_W-1:0] ab;
        logic [DM_W-1:0] dm;
        logic [5:0] exp_v;
        logic [5:0] held;
        int exp_n, bc;
        bit f7, f5, f4, f1, fail, srr;
        string tag;
        f7 = fidx[3]; f5 = fidx[2]; f4 = fidx[1]; f1 = fidx[0];
        // bits 6, 3, 2 and 0 carry noise that must be ignored
        fl = {f7, fidx[0] ^ fidx[3], f5, f4, fidx[2], fidx[1] ^ fidx[0], f1, ~fidx[2]};
        ab = 3'(fidx % 5);
        dm = 5'(8 + fidx);
        resp_stat = {7'h55, wip} ^ {7'h2A, 1'b0};
        resp_flag = fl;
        resp_stat_unsup = (unmode == 2);
        resp_flag_unsup = (unmode == 1);
        octal_mode = mode;
        oct_addr_bytes = ab;
        oct_dummy = dm;
        run_poll(extra, bc);
        octal_mode = 1'b0;
        oct_addr_bytes = '0;
        srr = !wip;
        fail = f5 | f4;
        if (unmode == 2) begin
            tag = "R9"; exp_n = 1; exp_v = 6'b010000;
        end else if (unmode == 1) begin
            tag = "R8"; exp_n = 2; exp_v = {srr, 5'b00000};
        end else if (fail) begin
            tag = "R6 R7"; exp_n = 4; exp_v = {1'b0, 1'b1, 1'b0, f5, f4 & !f5, f1};
        end else begin
            tag = "R5"; exp_n = 2; exp_v = {srr & f7, 5'b00000};
        end
        chk({tag, " verdict"}, {26'd0, verdict_vec()}, {26'd0, exp_v});
        chk({tag, " command count"}, lg_n, exp_n);
        chk_cmd(0, mode ? "R4 status read" : "R2 status read", 8'h05,
                mode ? ab : '0, mode ? dm : '0, mode ? 2'd2 : 2'd1, mode);
        if (exp_n > 1)
            chk_cmd(1, mode ? "R4 flag read" : "R3 flag read", 8'h70,
                    mode ? ab : '0, mode ? dm : '0, mode ? 2'd2 : 2'd1, mode);
        if (exp_n > 3) begin
            chk_cmd(2, "R6 clear flags", 8'h50, '0, '0, 2'd0, mode);
            chk_cmd(3, "R6 write disable", 8'h04, '0, '0, 2'd0, mode);
        end
        held = verdict_vec();
        @(negedge clk);
        @(negedge clk);
        chk("R11 done pulse and held verdict", {25'd0, done, verdict_vec()}, {25'd0, 1'b0, held});
    endtask

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs",
            {23'd0, busy, done, cmd_valid, ready, io_err, timeout_err, err_erase, err_program, err_protect},
            32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {29'd0, busy, done, cmd_valid}, 32'd0);

        for (int m = 0; m < 2; m++)
            for (int u = 0; u < 3; u++)
                for (int w = 0; w < 2; w++)
                    for (int f = 0; f < 16; f++)
                        sweep_case(m[0], u, w[0], f, (f == 5) || (f == 12));

        // R10 engine never accepts
        stall_accept = 1'b1;
        run_poll(1'b0, bc);
        chk("R10 busy cycles (no accept)", bc, TMO);
        chk("R10 verdict (no accept)", {26'd0, verdict_vec()}, {26'd0, 6'b001000});
        chk("R10 request dropped", {31'd0, cmd_valid}, 32'd0);
        stall_accept = 1'b0;
        repeat (4) @(negedge clk);

        // R10 engine accepts but never completes
        stall_fin = 1'b1;
        run_poll(1'b0, bc);
        chk("R10 busy cycles (no completion)", bc, TMO);
        chk("R10 verdict (no completion)", {26'd0, verdict_vec()}, {26'd0, 6'b001000});
        stall_fin = 1'b0;
        repeat (4) @(negedge clk);

        // recovery after a timeout: ordinary ready poll
        sweep_case(1'b0, 0, 1'b0, 8, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule